// File: doc/BRIEF.md
# Fractional Power Unit

This block raises an unsigned fixed-point value to a fractional exponent between zero and one without any logarithm or exponential hardware. The exponent arrives as a 9-bit binary fraction. The unit derives the chain x^(1/2), x^(1/4), x^(1/8) and so on, each term the square root of the one before. Each term whose exponent bit is set is multiplied into a running product, and that product starts at 1.0.

A caller drives the operand, the exponent code and a complement select, then pulses `start`. The operands are latched on that cycle. Later the unit raises `done` for one cycle, and the result is valid in that cycle. With the complement select high the unit uses the exponent 1 − γ. This lets one stored exponent serve both a scaling law and its counterpart. The square roots are computed bit-serially, so one evaluation takes about twenty cycles per exponent bit.

Top module: `fpow_unit`

## Requirements
- R1: `x_in` and `result_out` are unsigned Q1.15, so 0x8000 is 1.0. For an effective exponent code e, the result is within 12 LSB of x^(e/512).
- R2: The exponent bits are weighted from the most significant bit down. Bit 8 counts 1/2, bit 7 counts 1/4, and so on down to bit 0, which counts 1/512.
- R3: With `comp_in` = 1 the effective code is e = (512 − `gamma_in`) mod 512. With `comp_in` = 0 it is e = `gamma_in`.
- R4: An effective code of 0 yields exactly 0x8000 for any `x_in`.
- R5: `x_in` = 0 with a nonzero effective code yields exactly 0x0000.
- R6: Each accepted start produces exactly one `done` pulse, one cycle wide. The result is valid while `done` is high and is held unchanged until the next accepted start.
- R7: Operands are captured when a start is accepted. A `start` pulse, or a change of `x_in`, `gamma_in` or `comp_in`, while an evaluation is running has no effect on the outcome and produces no extra `done`.
- R8: While reset is asserted, `done_out` is low and `result_out` reads 0x8000. Asserting reset abandons any evaluation in progress.
- R9: `x_in` = 0x8000 yields exactly 0x8000 for any effective code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an evaluation, accepted only when idle |
| x_in | input | 16 | Base, unsigned Q1.15 |
| gamma_in | input | 9 | Exponent as a binary fraction, MSB weight 1/2 |
| comp_in | input | 1 | Use the exponent 1 − γ instead of γ |
| result_out | output | 16 | x raised to the effective exponent, unsigned Q1.15 |
| done_out | output | 1 | One-cycle pulse when the result is valid |

## Verification
The bench builds the unit with its default 16-bit data width and 9-bit exponent. At that size the exponent codes nearest 0.567, 0.806 and 0.618, and their complements, can be checked against a real-valued power. The bases tested range from 1/128 up to just under 2.0. The exact corners are checked separately: a zero exponent, a zero base and a unit base. Further tests cover a complement that must match the directly coded exponent, a second start issued during a run, and a reset that cuts a run short.

// File: rtl/fpow_pkg.sv
package fpow_pkg;

    // Sequencer phases of the power unit
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_MUL    = 2'd3
    } fpow_state_e;

endpackage

// File: rtl/fpow_expsel.sv
// Picks the effective exponent code: either gamma itself or its
// two's-complement fraction, which equals 1 - gamma modulo one.
module fpow_expsel #(
    parameter int EXP_W = 9
) (
    input  logic [EXP_W-1:0] gamma_i,
    input  logic             comp_i,
    output logic [EXP_W-1:0] code_o
);
    logic [EXP_W-1:0] neg_code;

    always_comb begin
        neg_code = (~gamma_i) + EXP_W'(1);
        code_o   = comp_i ? neg_code : gamma_i;
    end
endmodule

// File: rtl/fpow_qmul.sv
// Fixed-point product with round-half-up and saturation at full scale.
module fpow_qmul #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 15
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] p_o
);
    localparam int PROD_W = 2 * DATA_W;
    localparam logic [PROD_W-1:0] HALF  = PROD_W'(1) << (FRAC_W - 1);
    localparam logic [PROD_W-1:0] LIMIT = PROD_W'({DATA_W{1'b1}});

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;

    always_comb begin
        prod   = PROD_W'(a_i) * PROD_W'(b_i) + HALF;
        scaled = prod >> FRAC_W;
        p_o    = (scaled > LIMIT) ? {DATA_W{1'b1}} : DATA_W'(scaled);
    end
endmodule

// File: rtl/fpow_isqrt.sv
// Bit-serial restoring square root for unsigned fixed-point data.
// One result bit per cycle; an extra guard bit gives a rounded root.
module fpow_isqrt #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] rad_i,
    output logic [DATA_W-1:0] root_o,
    output logic              valid_o
);
    localparam int STEPS = DATA_W + 1;
    localparam int RAD_W = 2 * STEPS;
    localparam int REM_W = STEPS + 3;
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    typedef struct packed {
        logic             run;
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [RAD_W-1:0] rad;
        logic [REM_W-1:0] rem;
        logic [STEPS-1:0] root;
    } sq_t;

    sq_t sq_d, sq_q;
    logic [REM_W-1:0] rem_t;
    logic [REM_W-1:0] trial;
    logic [STEPS:0]   rnd;

    always_comb begin
        sq_d       = sq_q;
        sq_d.valid = 1'b0;
        rem_t      = {sq_q.rem[REM_W-3:0], sq_q.rad[RAD_W-1 -: 2]};
        trial      = REM_W'({sq_q.root, 2'b01});
        if (start_i) begin
            sq_d.run  = 1'b1;
            sq_d.cnt  = '0;
            sq_d.rad  = RAD_W'(rad_i) << (FRAC_W + 2);
            sq_d.rem  = '0;
            sq_d.root = '0;
        end else if (sq_q.run) begin
            if (rem_t >= trial) begin
                sq_d.rem  = rem_t - trial;
                sq_d.root = {sq_q.root[STEPS-2:0], 1'b1};
            end else begin
                sq_d.rem  = rem_t;
                sq_d.root = {sq_q.root[STEPS-2:0], 1'b0};
            end
            sq_d.rad = sq_q.rad << 2;
            sq_d.cnt = sq_q.cnt + CNT_W'(1);
            if (sq_q.cnt == LAST) begin
                sq_d.run   = 1'b0;
                sq_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    always_comb begin
        rnd    = {1'b0, sq_q.root} + (STEPS + 1)'(1);
        root_o = DATA_W'(rnd >> 1);
    end

    assign valid_o = sq_q.valid;
endmodule

// File: rtl/fpow_unit.sv
// Fractional power by binary expansion of the exponent:
// x^g = product over set bits k of x^(2^-k), each term the root of the last.
module fpow_unit #(
    parameter int DATA_W = 16,
    parameter int EXP_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] x_in,
    input  logic [EXP_W-1:0]  gamma_in,
    input  logic              comp_in,
    output logic [DATA_W-1:0] result_out,
    output logic              done_out
);
    import fpow_pkg::*;

    localparam int FRAC_W = DATA_W - 1;
    localparam int CNT_W  = $clog2(EXP_W + 1);
    localparam logic [CNT_W-1:0]  LAST = CNT_W'(EXP_W - 1);
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1) << FRAC_W;

    typedef struct packed {
        fpow_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic [EXP_W-1:0] code;
        logic [DATA_W-1:0] root;
        logic [DATA_W-1:0] acc;
        logic             done;
    } pw_t;

    pw_t pw_d, pw_q;

    logic [EXP_W-1:0]  eff_code;
    logic [DATA_W-1:0] mul_out;
    logic [DATA_W-1:0] sq_root;
    logic              sq_valid;
    logic              sq_start;

    fpow_expsel #(.EXP_W(EXP_W)) u_expsel (
        .gamma_i (gamma_in),
        .comp_i  (comp_in),
        .code_o  (eff_code)
    );

    fpow_isqrt #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_isqrt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sq_start),
        .rad_i   (pw_q.root),
        .root_o  (sq_root),
        .valid_o (sq_valid)
    );

    fpow_qmul #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_qmul (
        .a_i (pw_q.acc),
        .b_i (pw_q.root),
        .p_o (mul_out)
    );

    always_comb begin
        pw_d      = pw_q;
        pw_d.done = 1'b0;
        sq_start  = 1'b0;
        case (pw_q.state)
            ST_IDLE: begin
                if (start) begin
                    pw_d.state = ST_LAUNCH;
                    pw_d.code  = eff_code;
                    pw_d.root  = x_in;
                    pw_d.acc   = ONE;
                    pw_d.cnt   = '0;
                end
            end
            ST_LAUNCH: begin
                sq_start   = 1'b1;
                pw_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (sq_valid) begin
                    pw_d.root  = sq_root;
                    pw_d.state = ST_MUL;
                end
            end
            ST_MUL: begin
                if (pw_q.code[EXP_W-1]) begin
                    pw_d.acc = mul_out;
                end
                pw_d.code = pw_q.code << 1;
                pw_d.cnt  = pw_q.cnt + CNT_W'(1);
                if (pw_q.cnt == LAST) begin
                    pw_d.state = ST_IDLE;
                    pw_d.done  = 1'b1;
                end else begin
                    pw_d.state = ST_LAUNCH;
                end
            end
            default: pw_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_q       <= '0;
            pw_q.state <= ST_IDLE;
            pw_q.acc   <= ONE;
        end else begin
            pw_q <= pw_d;
        end
    end

    assign result_out = pw_q.acc;
    assign done_out   = pw_q.done;
endmodule

// File: rtl/fpow_chk.sv
// Protocol and corner-value checks for fpow_unit, attached by bind.
module fpow_chk #(
    parameter int DATA_W = 16,
    parameter int EXP_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [DATA_W-1:0] x_i,
    input logic [EXP_W-1:0]  gamma_i,
    input logic              comp_i,
    input logic [DATA_W-1:0] result_i,
    input logic              done_i
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1) << (DATA_W - 1);

    logic              trk_busy;
    logic [DATA_W-1:0] cap_x;
    logic [EXP_W-1:0]  cap_code;
    logic [EXP_W-1:0]  code_now;

    assign code_now = comp_i ? (EXP_W'(0) - gamma_i) : gamma_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_busy <= 1'b0;
            cap_x    <= '0;
            cap_code <= '0;
        end else if (start_i && (!trk_busy || done_i)) begin
            trk_busy <= 1'b1;
            cap_x    <= x_i;
            cap_code <= code_now;
        end else if (done_i) begin
            trk_busy <= 1'b0;
        end
    end

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !done_i);

    a_r7_done_needs_job: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> trk_busy);

    a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!trk_busy && !start_i) |=> $stable(result_i));

    a_r4_zero_exponent: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cap_code == '0) |-> result_i == ONE);

    a_r5_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cap_x == '0 && cap_code != '0) |-> result_i == '0);

    a_r9_unit_base: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cap_x == ONE) |-> result_i == ONE);
endmodule

bind fpow_unit fpow_chk #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .x_i      (x_in),
    .gamma_i  (gamma_in),
    .comp_i   (comp_in),
    .result_i (result_out),
    .done_i   (done_out)
);

// File: tb/sim_fpow_unit.sv
module sim_fpow_unit;
    localparam int TOL = 12;
    localparam int NV  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] x_in = '0;
    logic [8:0]  gamma_in = '0;
    logic        comp_in = 1'b0;
    logic [15:0] result_out;
    logic        done_out;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fpow_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
        .gamma_in(gamma_in), .comp_in(comp_in),
        .result_out(result_out), .done_out(done_out)
    );

    // {x, gamma, comp}
    localparam logic [25:0] VEC [NV] = '{
        {16'h4000, 9'h122, 1'b0}, {16'h4000, 9'h122, 1'b1},
        {16'h6000, 9'h19D, 1'b0}, {16'h6000, 9'h19D, 1'b1},
        {16'hC000, 9'h13C, 1'b0}, {16'hC000, 9'h13C, 1'b1},
        {16'h0100, 9'h100, 1'b0}, {16'hFFFF, 9'h1FF, 1'b0},
        {16'h2000, 9'h001, 1'b0}, {16'h1234, 9'h0AB, 1'b0},
        {16'hF000, 9'h155, 1'b1}, {16'h0800, 9'h0F0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input logic [8:0] g, input logic c);
        return c ? ((512 - int'(g)) % 512) : int'(g);
    endfunction

    function automatic int ideal(input logic [15:0] x, input int code);
        real xr, gr, v;
        if (code == 0) return 32768;
        if (x == 16'h0) return 0;
        xr = real'(x) / 32768.0;
        gr = real'(code) / 512.0;
        v  = xr ** gr;
        return $rtoi(v * 32768.0 + 0.5);
    endfunction

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic run_op(input logic [15:0] x, input logic [8:0] g, input logic c,
                          output int r);
        int n;
        @(negedge clk);
        x_in = x; gamma_in = g; comp_in = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done_out && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(done_out == 1'b1, "R6 done timeout", int'(done_out), 1);
        r = int'(result_out);
        @(negedge clk);
        check(done_out == 1'b0, "R6 done width", int'(done_out), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        int r, r2, e, ndone, first;
        // R8: reset state
        repeat (3) @(negedge clk);
        check(done_out == 1'b0, "R8 done in reset", int'(done_out), 0);
        check(result_out == 16'h8000, "R8 result in reset", int'(result_out), 32768);
        rst_n = 1'b1;

        // R1/R2/R3: table walk against real power
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][25:10], VEC[i][9:1], VEC[i][0], r);
            e = ideal(VEC[i][25:10], eff(VEC[i][9:1], VEC[i][0]));
            check(absdiff(r, e) <= TOL, "R1 power accuracy", r, e);
        end

        // R2: single bit weights
        run_op(16'h4000, 9'h100, 1'b0, r);
        check(absdiff(r, 23170) <= TOL, "R2 msb weight half", r, 23170);
        run_op(16'h1000, 9'h080, 1'b0, r);
        check(absdiff(r, 19484) <= TOL, "R2 bit7 weight quarter", r, 19484);

        // R3: complement equals direct code
        run_op(16'h5000, 9'h0C3, 1'b1, r);
        run_op(16'h5000, 9'd317, 1'b0, r2);
        check(r == r2, "R3 complement code", r, r2);

        // R4: zero effective exponent
        run_op(16'h3000, 9'h000, 1'b0, r);
        check(r == 32768, "R4 gamma zero", r, 32768);
        run_op(16'hFFFF, 9'h000, 1'b1, r);
        check(r == 32768, "R4 complement of zero", r, 32768);

        // R5: zero base
        run_op(16'h0000, 9'h0A5, 1'b0, r);
        check(r == 0, "R5 zero base", r, 0);

        // R9: unit base
        run_op(16'h8000, 9'h1FF, 1'b0, r);
        check(r == 32768, "R9 unit base", r, 32768);

        // R7: start and operand changes while busy are ignored
        @(negedge clk);
        x_in = 16'h6000; gamma_in = 9'h122; comp_in = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        x_in = 16'h1000; gamma_in = 9'h1FF; comp_in = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ndone = 0; first = -1;
        for (int n = 0; n < 600; n++) begin
            if (done_out) begin
                ndone++;
                if (first < 0) first = int'(result_out);
            end
            @(negedge clk);
        end
        e = ideal(16'h6000, 290);
        check(ndone == 1, "R7 single done", ndone, 1);
        check(absdiff(first, e) <= TOL, "R7 first operands kept", first, e);
        check(int'(result_out) == first, "R6 result held", int'(result_out), first);

        // R8: reset mid-run abandons the job
        @(negedge clk);
        x_in = 16'h4000; gamma_in = 9'h1AA; comp_in = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(result_out == 16'h8000, "R8 reset mid-run result", int'(result_out), 32768);
        rst_n = 1'b1;
        ndone = 0;
        for (int n = 0; n < 300; n++) begin
            if (done_out) ndone++;
            @(negedge clk);
        end
        check(ndone == 0, "R8 no done after reset", ndone, 0);
        run_op(16'h4000, 9'h122, 1'b0, r);
        e = ideal(16'h4000, 290);
        check(absdiff(r, e) <= TOL, "R8 operation after reset", r, e);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule